// File: doc/BRIEF.md
# Isochronous Cycle Timer with Timestamp and Late-Packet Gate

The block keeps a bus cycle timer made of two fields: a fine offset that advances on every tick of a 24.576 MHz enable and rolls over after 3072 ticks, and a coarse cycle count that advances once per 125 µs rollover. The same time base serves two paths. On the transmit path each accepted source packet is stamped with the current time plus a programmable lead. While that packet waits for the link, the block watches it. Once the stamp has fallen further behind the current time than a programmable late window allows, the packet is turned into an empty packet and a transmit-late pulse follows its handshake.

On the receive path each incoming source packet carries a stamp from its header. A packet whose stamp is already too far behind is dropped and a receive-late pulse is raised. A packet whose stamp is behind but still inside the window is passed on at once. A packet whose stamp lies ahead is held until the timer equals the stamp, and is then offered downstream. Software reads the timer as a high word followed by a low word. The high-word read also captures the offset, so the pair always describes one instant. A load port lets the cycle-start logic align the timer.

Both packet paths use valid/ready. On an input, a transfer happens in any cycle where valid and ready are both high. An output holds its valid, tag and stamp unchanged until ready is seen high. The one exception is the transmit empty flag: it may rise while the packet waits and then never falls.

Top module: `isoc_ts_gate`

## Requirements
- R1: After reset the timer reads count 0, offset 0. Each cycle with `tick` high advances the offset by one. An offset of 3071 wraps to 0 and increments the count. The count wraps modulo 2^CNT_W.
- R2: A cycle with `load_valid` high sets the timer to `load_cnt`/`load_off` and ignores `tick` in that cycle.
- R3: The cycle after `rd_hi`, `rd_data` holds the count, zero-extended, and the current offset is captured. The cycle after `rd_lo`, `rd_data` holds the captured offset, even if the timer has changed since. If both strobes are high together, `rd_hi` wins.
- R4: A packet accepted on the transmit input is stamped with the current time plus the lead `cfg_tx_off_cnt`/`cfg_tx_off_fine`. The offset sum is reduced by 3072 when it reaches 3072, and that reduction adds one to the count, modulo 2^CNT_W.
- R5: `s_tx_ready` is high when the transmit output is empty or is being taken in the same cycle. While `m_tx_valid` is high and `m_tx_ready` is low, the tag and stamp stay stable.
- R6: A waiting transmit packet that becomes late gets `m_tx_empty` set. The flag stays set until the packet is taken. One cycle after a packet leaves with `m_tx_empty` high, `irq_tx_late` is high for one cycle.
- R7: Late means the current time minus the stamp, taken modulo the full timer range, is less than half that range and strictly greater than the window. The window is `cfg_win_cnt`×3072 + `cfg_win_fine`×16 ticks.
- R8: A received packet whose stamp lies ahead of the timer is held, with `m_rx_valid` low. `m_rx_valid` rises in the cycle after the timer equals the stamp.
- R9: A received packet whose stamp equals the timer or is behind it by no more than the window is offered on the cycle after acceptance.
- R10: A late received packet is accepted and discarded. `irq_rx_late` is high for one cycle right after acceptance, and `m_rx_valid` stays low.
- R11: `s_rx_ready` is high only when no received packet is waiting or being offered. `m_rx_valid` and `m_rx_tag` hold until `m_rx_ready` is seen high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One 24.576 MHz tick per high cycle |
| load_valid | input | 1 | Load the timer this cycle |
| load_cnt | input | CNT_W | Cycle count to load |
| load_off | input | 12 | Offset to load (0..3071) |
| rd_hi | input | 1 | Read high word (count) and capture the offset |
| rd_lo | input | 1 | Read the captured offset |
| rd_data | output | 16 | Read data, valid the cycle after a strobe |
| cyc_cnt | output | CNT_W | Live cycle count |
| cyc_off | output | 12 | Live cycle offset |
| cfg_tx_off_cnt | input | 8 | Transmit lead, cycle part |
| cfg_tx_off_fine | input | 12 | Transmit lead, tick part (0..3072) |
| cfg_win_cnt | input | 8 | Late window, cycle part |
| cfg_win_fine | input | 8 | Late window, 16-tick part (0..192) |
| s_tx_valid | input | 1 | Transmit packet offered |
| s_tx_ready | output | 1 | Transmit packet accepted |
| s_tx_tag | input | TAG_W | Transmit packet handle |
| m_tx_valid | output | 1 | Stamped packet offered to link |
| m_tx_ready | input | 1 | Link takes the packet |
| m_tx_tag | output | TAG_W | Handle of the stamped packet |
| m_tx_stamp_cnt | output | CNT_W | Stamp, cycle count |
| m_tx_stamp_off | output | 12 | Stamp, offset |
| m_tx_empty | output | 1 | Send an empty packet in place of this one |
| s_rx_valid | input | 1 | Received packet offered |
| s_rx_ready | output | 1 | Received packet accepted |
| s_rx_tag | input | TAG_W | Received packet handle |
| s_rx_stamp_cnt | input | CNT_W | Header stamp, cycle count |
| s_rx_stamp_off | input | 12 | Header stamp, offset (0..3071) |
| m_rx_valid | output | 1 | Packet released downstream |
| m_rx_ready | input | 1 | Downstream takes the packet |
| m_rx_tag | output | TAG_W | Handle of the released packet |
| irq_tx_late | output | 1 | Pulse: a late transmit packet left as empty |
| irq_rx_late | output | 1 | Pulse: a late received packet was dropped |

## Verification
A timer whose offset wraps at the wrong value shows on `cyc_off` within one tick of 3071. It also skews every stamp on `m_tx_stamp_cnt`/`m_tx_stamp_off` the next time a packet is accepted. A wrong borrow or window scaling in the lateness arithmetic shows only at the boundaries, as `m_tx_empty` or `irq_rx_late` arriving one tick early or late. The tests therefore place the timer exactly at the window edge, and across the count wrap, with the tick stopped. A receive gate stuck in its hold state shows as `s_rx_ready` staying low and `m_rx_valid` never rising in the cycle after the timer reaches the stamp.

// File: rtl/isoc_ts_pkg.sv
package isoc_ts_pkg;
  // Width of the fine offset field and its rollover value (ticks per cycle).
  localparam int OFF_W   = 12;
  localparam int OFF_MOD = 3072;
  // The late window fine field counts in groups of 2**FINE_SH ticks.
  localparam int FINE_SH = 4;
  // Width of the configuration cycle fields.
  localparam int CFG_CW  = 8;
  localparam int WORD_W  = 16;

  typedef enum logic [1:0] {
    RX_IDLE = 2'd0,
    RX_WAIT = 2'd1,
    RX_OUT  = 2'd2
  } rx_state_e;
endpackage

// File: rtl/isoc_cycle_timer.sv
module isoc_cycle_timer
  import isoc_ts_pkg::*;
#(
  parameter int CNT_W = 13
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  logic                load_valid,
  input  logic [CNT_W-1:0]    load_cnt,
  input  logic [OFF_W-1:0]    load_off,
  input  logic                rd_hi,
  input  logic                rd_lo,
  output logic [CNT_W-1:0]    cnt_o,
  output logic [OFF_W-1:0]    off_o,
  output logic [WORD_W-1:0]   rd_data
);
  localparam logic [OFF_W-1:0] OFF_LAST = OFF_W'(OFF_MOD - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [OFF_W-1:0] off_q;
  logic [OFF_W-1:0] snap_q;
  logic             wrap;

  assign wrap = (off_q == OFF_LAST);

  // Mixed-radix counter: the offset rolls over at 3072, which steps the count.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      off_q <= '0;
    end else if (load_valid) begin
      cnt_q <= load_cnt;
      off_q <= load_off;
    end else if (tick) begin
      if (wrap) begin
        off_q <= '0;
        cnt_q <= cnt_q + 1'b1;
      end else begin
        off_q <= off_q + 1'b1;
      end
    end
  end

  // Word-pair read: the high read captures the offset for the later low read.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      snap_q  <= '0;
      rd_data <= '0;
    end else if (rd_hi) begin
      snap_q  <= off_q;
      rd_data <= WORD_W'(cnt_q);
    end else if (rd_lo) begin
      rd_data <= WORD_W'(snap_q);
    end
  end

  assign cnt_o = cnt_q;
  assign off_o = off_q;
endmodule

// File: rtl/isoc_time_diff.sv
module isoc_time_diff
  import isoc_ts_pkg::*;
#(
  parameter int CNT_W = 13
) (
  input  logic [CNT_W-1:0]  now_cnt,
  input  logic [OFF_W-1:0]  now_off,
  input  logic [CNT_W-1:0]  ref_cnt,
  input  logic [OFF_W-1:0]  ref_off,
  input  logic [CFG_CW-1:0] win_cnt,
  input  logic [CFG_CW-1:0] win_fine,
  output logic              behind,
  output logic              late
);
  localparam int LIN_W = CNT_W + OFF_W;

  logic [OFF_W:0]   off_raw;
  logic             borrow;
  logic [OFF_W-1:0] off_d;
  logic [CNT_W-1:0] cnt_d;
  logic [LIN_W-1:0] diff_lin;
  logic [LIN_W-1:0] win_lin;

  // Field-wise subtraction: a negative offset difference borrows one cycle.
  always_comb begin
    off_raw = {1'b0, now_off} - {1'b0, ref_off};
    borrow  = off_raw[OFF_W];
    off_d   = borrow ? (off_raw[OFF_W-1:0] + OFF_W'(OFF_MOD)) : off_raw[OFF_W-1:0];
    cnt_d   = now_cnt - ref_cnt - CNT_W'(borrow);
  end

  // Flatten both quantities into ticks: x*3072 = (x<<11) + (x<<10).
  always_comb begin
    diff_lin = (LIN_W'(cnt_d) << 11) + (LIN_W'(cnt_d) << 10) + LIN_W'(off_d);
    win_lin  = (LIN_W'(win_cnt) << 11) + (LIN_W'(win_cnt) << 10)
             + (LIN_W'(win_fine) << FINE_SH);
  end

  // Behind by less than half the range counts as "behind"; else it is ahead.
  assign behind = ~cnt_d[CNT_W-1];
  assign late   = behind & (diff_lin > win_lin);
endmodule

// File: rtl/isoc_tx_stamper.sv
module isoc_tx_stamper
  import isoc_ts_pkg::*;
#(
  parameter int CNT_W = 13,
  parameter int TAG_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  now_cnt,
  input  logic [OFF_W-1:0]  now_off,
  input  logic [CFG_CW-1:0] lead_cnt,
  input  logic [OFF_W-1:0]  lead_fine,
  input  logic [CFG_CW-1:0] win_cnt,
  input  logic [CFG_CW-1:0] win_fine,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [TAG_W-1:0]  s_tag,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [TAG_W-1:0]  m_tag,
  output logic [CNT_W-1:0]  m_cnt,
  output logic [OFF_W-1:0]  m_off,
  output logic              m_empty,
  output logic              irq_late
);
  logic [OFF_W:0]   off_sum;
  logic             carry;
  logic [OFF_W-1:0] st_off;
  logic [CNT_W-1:0] st_cnt;
  logic             held_late;
  logic             held_behind;

  logic             v_q;
  logic [TAG_W-1:0] tag_q;
  logic [CNT_W-1:0] cnt_q;
  logic [OFF_W-1:0] off_q;
  logic             empty_q;
  logic             irq_q;

  // Stamp = now + lead, carrying from offset into count at 3072.
  always_comb begin
    off_sum = {1'b0, now_off} + {1'b0, lead_fine};
    carry   = (off_sum >= (OFF_W+1)'(OFF_MOD));
    st_off  = carry ? OFF_W'(off_sum - (OFF_W+1)'(OFF_MOD)) : off_sum[OFF_W-1:0];
    st_cnt  = now_cnt + CNT_W'(lead_cnt) + CNT_W'(carry);
  end

  isoc_time_diff #(.CNT_W(CNT_W)) u_late (
    .now_cnt  (now_cnt),
    .now_off  (now_off),
    .ref_cnt  (cnt_q),
    .ref_off  (off_q),
    .win_cnt  (win_cnt),
    .win_fine (win_fine),
    .behind   (held_behind),
    .late     (held_late)
  );

  assign s_ready = ~v_q | m_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_q     <= 1'b0;
      tag_q   <= '0;
      cnt_q   <= '0;
      off_q   <= '0;
      empty_q <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      irq_q <= v_q & m_ready & empty_q;
      if (s_valid & s_ready) begin
        v_q     <= 1'b1;
        tag_q   <= s_tag;
        cnt_q   <= st_cnt;
        off_q   <= st_off;
        empty_q <= 1'b0;
      end else if (v_q & m_ready) begin
        v_q <= 1'b0;
      end else if (v_q & held_late) begin
        // Sticky: once late the slot goes out as an empty packet.
        empty_q <= 1'b1;
      end
    end
  end

  assign m_valid  = v_q;
  assign m_tag    = tag_q;
  assign m_cnt    = cnt_q;
  assign m_off    = off_q;
  assign m_empty  = empty_q;
  assign irq_late = irq_q;
endmodule

// File: rtl/isoc_rx_gate.sv
module isoc_rx_gate
  import isoc_ts_pkg::*;
#(
  parameter int CNT_W = 13,
  parameter int TAG_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  now_cnt,
  input  logic [OFF_W-1:0]  now_off,
  input  logic [CFG_CW-1:0] win_cnt,
  input  logic [CFG_CW-1:0] win_fine,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [TAG_W-1:0]  s_tag,
  input  logic [CNT_W-1:0]  s_cnt,
  input  logic [OFF_W-1:0]  s_off,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [TAG_W-1:0]  m_tag,
  output logic              irq_late
);
  rx_state_e        st_q;
  logic [TAG_W-1:0] tag_q;
  logic [CNT_W-1:0] cnt_q;
  logic [OFF_W-1:0] off_q;
  logic             irq_q;
  logic             in_behind;
  logic             in_late;
  logic             hit;

  // Lateness of the packet being offered, judged at acceptance.
  isoc_time_diff #(.CNT_W(CNT_W)) u_in (
    .now_cnt  (now_cnt),
    .now_off  (now_off),
    .ref_cnt  (s_cnt),
    .ref_off  (s_off),
    .win_cnt  (win_cnt),
    .win_fine (win_fine),
    .behind   (in_behind),
    .late     (in_late)
  );

  assign hit     = (now_cnt == cnt_q) && (now_off == off_q);
  assign s_ready = (st_q == RX_IDLE);
  assign m_valid = (st_q == RX_OUT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= RX_IDLE;
      tag_q <= '0;
      cnt_q <= '0;
      off_q <= '0;
      irq_q <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      unique case (st_q)
        RX_IDLE: begin
          if (s_valid) begin
            if (in_late) begin
              irq_q <= 1'b1;
            end else begin
              tag_q <= s_tag;
              cnt_q <= s_cnt;
              off_q <= s_off;
              st_q  <= in_behind ? RX_OUT : RX_WAIT;
            end
          end
        end
        RX_WAIT: if (hit) st_q <= RX_OUT;
        RX_OUT:  if (m_ready) st_q <= RX_IDLE;
        default: st_q <= RX_IDLE;
      endcase
    end
  end

  assign m_tag    = tag_q;
  assign irq_late = irq_q;
endmodule

// File: rtl/isoc_ts_gate.sv
module isoc_ts_gate
  import isoc_ts_pkg::*;
#(
  parameter int CNT_W = 13,
  parameter int TAG_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              load_valid,
  input  logic [CNT_W-1:0]  load_cnt,
  input  logic [11:0]       load_off,
  input  logic              rd_hi,
  input  logic              rd_lo,
  output logic [15:0]       rd_data,
  output logic [CNT_W-1:0]  cyc_cnt,
  output logic [11:0]       cyc_off,
  input  logic [7:0]        cfg_tx_off_cnt,
  input  logic [11:0]       cfg_tx_off_fine,
  input  logic [7:0]        cfg_win_cnt,
  input  logic [7:0]        cfg_win_fine,
  input  logic              s_tx_valid,
  output logic              s_tx_ready,
  input  logic [TAG_W-1:0]  s_tx_tag,
  output logic              m_tx_valid,
  input  logic              m_tx_ready,
  output logic [TAG_W-1:0]  m_tx_tag,
  output logic [CNT_W-1:0]  m_tx_stamp_cnt,
  output logic [11:0]       m_tx_stamp_off,
  output logic              m_tx_empty,
  input  logic              s_rx_valid,
  output logic              s_rx_ready,
  input  logic [TAG_W-1:0]  s_rx_tag,
  input  logic [CNT_W-1:0]  s_rx_stamp_cnt,
  input  logic [11:0]       s_rx_stamp_off,
  output logic              m_rx_valid,
  input  logic              m_rx_ready,
  output logic [TAG_W-1:0]  m_rx_tag,
  output logic              irq_tx_late,
  output logic              irq_rx_late
);
  logic [CNT_W-1:0] now_cnt;
  logic [OFF_W-1:0] now_off;

  isoc_cycle_timer #(.CNT_W(CNT_W)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .load_valid (load_valid),
    .load_cnt   (load_cnt),
    .load_off   (load_off),
    .rd_hi      (rd_hi),
    .rd_lo      (rd_lo),
    .cnt_o      (now_cnt),
    .off_o      (now_off),
    .rd_data    (rd_data)
  );

  isoc_tx_stamper #(.CNT_W(CNT_W), .TAG_W(TAG_W)) u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .now_cnt   (now_cnt),
    .now_off   (now_off),
    .lead_cnt  (cfg_tx_off_cnt),
    .lead_fine (cfg_tx_off_fine),
    .win_cnt   (cfg_win_cnt),
    .win_fine  (cfg_win_fine),
    .s_valid   (s_tx_valid),
    .s_ready   (s_tx_ready),
    .s_tag     (s_tx_tag),
    .m_valid   (m_tx_valid),
    .m_ready   (m_tx_ready),
    .m_tag     (m_tx_tag),
    .m_cnt     (m_tx_stamp_cnt),
    .m_off     (m_tx_stamp_off),
    .m_empty   (m_tx_empty),
    .irq_late  (irq_tx_late)
  );

  isoc_rx_gate #(.CNT_W(CNT_W), .TAG_W(TAG_W)) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .now_cnt  (now_cnt),
    .now_off  (now_off),
    .win_cnt  (cfg_win_cnt),
    .win_fine (cfg_win_fine),
    .s_valid  (s_rx_valid),
    .s_ready  (s_rx_ready),
    .s_tag    (s_rx_tag),
    .s_cnt    (s_rx_stamp_cnt),
    .s_off    (s_rx_stamp_off),
    .m_valid  (m_rx_valid),
    .m_ready  (m_rx_ready),
    .m_tag    (m_rx_tag),
    .irq_late (irq_rx_late)
  );

  assign cyc_cnt = now_cnt;
  assign cyc_off = now_off;
endmodule

// File: rtl/isoc_ts_gate_chk.sv
module isoc_ts_gate_chk #(
  parameter int CNT_W = 13,
  parameter int TAG_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             load_valid,
  input logic [CNT_W-1:0] cyc_cnt,
  input logic [11:0]      cyc_off,
  input logic             m_tx_valid,
  input logic             m_tx_ready,
  input logic [TAG_W-1:0] m_tx_tag,
  input logic [CNT_W-1:0] m_tx_stamp_cnt,
  input logic [11:0]      m_tx_stamp_off,
  input logic             m_tx_empty,
  input logic             s_rx_valid,
  input logic             s_rx_ready,
  input logic             m_rx_valid,
  input logic             m_rx_ready,
  input logic [TAG_W-1:0] m_rx_tag,
  input logic             irq_tx_late,
  input logic             irq_rx_late
);
  // R1: offset never leaves 0..3071
  p_off_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_off < 12'd3072);

  // R1: rollover of the offset steps the count
  p_wrap_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load_valid && cyc_off == 12'd3071) |=>
      (cyc_off == 12'd0 && cyc_cnt == CNT_W'($past(cyc_cnt) + 1'b1)));

  // R5: stamp and tag hold while the link stalls
  p_tx_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (m_tx_valid && !m_tx_ready) |=>
      (m_tx_valid && $stable(m_tx_tag) && $stable(m_tx_stamp_cnt) && $stable(m_tx_stamp_off)));

  // R6: the empty flag never falls while the packet waits
  p_tx_empty_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (m_tx_valid && !m_tx_ready && m_tx_empty) |=> m_tx_empty);

  // R6: transmit-late pulse only after an empty packet left
  p_tx_irq_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_tx_late |-> $past(m_tx_valid && m_tx_ready && m_tx_empty));

  // R10: receive-late pulse only right after an acceptance
  p_rx_irq_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_rx_late |-> $past(s_rx_valid && s_rx_ready));

  // R10: a dropped packet never appears downstream
  p_rx_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_rx_late |-> !m_rx_valid);

  // R11: released packet holds until taken
  p_rx_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (m_rx_valid && !m_rx_ready) |=> (m_rx_valid && $stable(m_rx_tag)));

  // R11: no acceptance while a packet is being offered
  p_rx_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    m_rx_valid |-> !s_rx_ready);
endmodule

bind isoc_ts_gate isoc_ts_gate_chk #(.CNT_W(CNT_W), .TAG_W(TAG_W)) u_chk (.*);

// File: tb/tb_isoc_ts_gate.sv
`timescale 1ns/1ps
module tb_isoc_ts_gate;
  localparam int CNT_W = 13;
  localparam int TAG_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic load_valid = 1'b0;
  logic [CNT_W-1:0] load_cnt = '0;
  logic [11:0] load_off = '0;
  logic rd_hi = 1'b0, rd_lo = 1'b0;
  logic [15:0] rd_data;
  logic [CNT_W-1:0] cyc_cnt;
  logic [11:0] cyc_off;
  logic [7:0] cfg_tx_off_cnt = '0;
  logic [11:0] cfg_tx_off_fine = '0;
  logic [7:0] cfg_win_cnt = '0, cfg_win_fine = '0;
  logic s_tx_valid = 1'b0, s_tx_ready;
  logic [TAG_W-1:0] s_tx_tag = '0;
  logic m_tx_valid, m_tx_ready = 1'b0;
  logic [TAG_W-1:0] m_tx_tag;
  logic [CNT_W-1:0] m_tx_stamp_cnt;
  logic [11:0] m_tx_stamp_off;
  logic m_tx_empty;
  logic s_rx_valid = 1'b0, s_rx_ready;
  logic [TAG_W-1:0] s_rx_tag = '0;
  logic [CNT_W-1:0] s_rx_stamp_cnt = '0;
  logic [11:0] s_rx_stamp_off = '0;
  logic m_rx_valid, m_rx_ready = 1'b0;
  logic [TAG_W-1:0] m_rx_tag;
  logic irq_tx_late, irq_rx_late;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  isoc_ts_gate #(.CNT_W(CNT_W), .TAG_W(TAG_W)) dut (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic load_t(input int c, input int o);
    @(negedge clk);
    load_valid = 1'b1; load_cnt = CNT_W'(c); load_off = 12'(o);
    @(negedge clk);
    load_valid = 1'b0;
  endtask

  task automatic send_tx(input int tag);
    @(negedge clk);
    s_tx_valid = 1'b1; s_tx_tag = TAG_W'(tag);
    @(negedge clk);
    s_tx_valid = 1'b0;
  endtask

  task automatic send_rx(input int tag, input int c, input int o);
    @(negedge clk);
    s_rx_valid = 1'b1; s_rx_tag = TAG_W'(tag);
    s_rx_stamp_cnt = CNT_W'(c); s_rx_stamp_off = 12'(o);
    @(negedge clk);
    s_rx_valid = 1'b0;
  endtask

  task automatic take_rx();
    @(negedge clk); m_rx_ready = 1'b1;
    @(negedge clk); m_rx_ready = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 reset count", int'(cyc_cnt), 0);
    chk("R1 reset offset", int'(cyc_off), 0);
    chk("R5 reset tx valid", int'(m_tx_valid), 0);
    chk("R11 reset rx ready", int'(s_rx_ready), 1);
    chk("R11 reset rx valid", int'(m_rx_valid), 0);
  endtask

  task automatic t_timer();
    load_t(8191, 3071);
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    chk("R1 count wrap", int'(cyc_cnt), 0);
    chk("R1 offset wrap", int'(cyc_off), 0);
    @(negedge clk); tick = 1'b1;
    step(5); tick = 1'b0;
    chk("R1 five ticks", int'(cyc_off), 5);
    @(negedge clk);
    tick = 1'b1; load_valid = 1'b1; load_cnt = 13'd40; load_off = 12'd7;
    @(negedge clk);
    tick = 1'b0; load_valid = 1'b0;
    chk("R2 load beats tick", int'(cyc_off), 7);
    chk("R2 load count", int'(cyc_cnt), 40);
  endtask

  task automatic t_read();
    load_t(12'h123, 3071);
    @(negedge clk); rd_hi = 1'b1;
    @(negedge clk); rd_hi = 1'b0;
    chk("R3 high word", int'(rd_data), 12'h123);
    load_t(7, 5);
    @(negedge clk); rd_lo = 1'b1;
    @(negedge clk); rd_lo = 1'b0;
    chk("R3 captured low word", int'(rd_data), 3071);
    @(negedge clk); rd_hi = 1'b1; rd_lo = 1'b1;
    @(negedge clk); rd_hi = 1'b0; rd_lo = 1'b0;
    chk("R3 high read wins", int'(rd_data), 7);
  endtask

  task automatic t_tx_stamp();
    cfg_win_cnt = 8'd0; cfg_win_fine = 8'd2;
    cfg_tx_off_cnt = 8'd1; cfg_tx_off_fine = 12'd100;
    load_t(8191, 3000);
    send_tx(8'h5A);
    chk("R4 stamp count across wrap", int'(m_tx_stamp_cnt), 1);
    chk("R4 stamp offset carry", int'(m_tx_stamp_off), 28);
    chk("R5 tag", int'(m_tx_tag), 8'h5A);
    chk("R5 ready low while stalled", int'(s_tx_ready), 0);
    step(3);
    chk("R5 stamp stable", int'(m_tx_stamp_off), 28);
    chk("R6 not empty when ahead", int'(m_tx_empty), 0);
    @(negedge clk); m_tx_ready = 1'b1;
    @(negedge clk); m_tx_ready = 1'b0;
    chk("R6 no irq for full packet", int'(irq_tx_late), 0);
    chk("R5 drained", int'(m_tx_valid), 0);
    cfg_tx_off_cnt = 8'd0; cfg_tx_off_fine = 12'd3072;
    load_t(4, 0);
    send_tx(8'h11);
    chk("R4 full-cycle lead count", int'(m_tx_stamp_cnt), 5);
    chk("R4 full-cycle lead offset", int'(m_tx_stamp_off), 0);
    @(negedge clk); m_tx_ready = 1'b1;
    @(negedge clk); m_tx_ready = 1'b0;
  endtask

  task automatic t_tx_late();
    cfg_tx_off_cnt = 8'd0; cfg_tx_off_fine = 12'd0;
    cfg_win_cnt = 8'd0; cfg_win_fine = 8'd2;
    load_t(10, 0);
    send_tx(8'h33);
    load_t(10, 32);
    step(2);
    chk("R7 at window edge not late", int'(m_tx_empty), 0);
    load_t(10, 33);
    step(1);
    chk("R6 late sets empty", int'(m_tx_empty), 1);
    chk("R6 still offered", int'(m_tx_valid), 1);
    load_t(10, 0);
    step(2);
    chk("R6 empty sticky", int'(m_tx_empty), 1);
    @(negedge clk); m_tx_ready = 1'b1;
    @(negedge clk); m_tx_ready = 1'b0;
    chk("R6 tx late pulse", int'(irq_tx_late), 1);
    step(1);
    chk("R6 pulse one cycle", int'(irq_tx_late), 0);
  endtask

  task automatic t_rx_wait();
    cfg_win_cnt = 8'd0; cfg_win_fine = 8'd2;
    load_t(5, 100);
    send_rx(8'h44, 5, 103);
    chk("R11 ready low while held", int'(s_rx_ready), 0);
    chk("R8 held while ahead", int'(m_rx_valid), 0);
    @(negedge clk); tick = 1'b1;
    step(2); tick = 1'b0;
    chk("R8 still held one tick short", int'(m_rx_valid), 0);
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    @(negedge clk);
    chk("R8 released at stamp", int'(m_rx_valid), 1);
    chk("R8 tag", int'(m_rx_tag), 8'h44);
    step(2);
    chk("R11 hold until ready", int'(m_rx_valid), 1);
    take_rx();
    chk("R11 drained", int'(s_rx_ready), 1);
  endtask

  task automatic t_rx_window();
    cfg_win_cnt = 8'd0; cfg_win_fine = 8'd6;
    load_t(0, 10);
    send_rx(8'h22, 8191, 3000);
    chk("R9 behind within window across wrap", int'(m_rx_valid), 1);
    chk("R9 no late pulse", int'(irq_rx_late), 0);
    take_rx();
    cfg_win_fine = 8'd4;
    send_rx(8'h23, 8191, 3000);
    chk("R10 late pulse across wrap", int'(irq_rx_late), 1);
    chk("R10 not offered", int'(m_rx_valid), 0);
    chk("R10 ready again", int'(s_rx_ready), 1);
    step(3);
    chk("R10 dropped stays dropped", int'(m_rx_valid), 0);
    cfg_win_cnt = 8'd1; cfg_win_fine = 8'd0;
    load_t(4, 0);
    send_rx(8'h24, 3, 0);
    chk("R7 one-cycle window edge", int'(m_rx_valid), 1);
    take_rx();
    load_t(4, 1);
    send_rx(8'h25, 3, 0);
    chk("R7 one tick past cycle window", int'(irq_rx_late), 1);
    load_t(4, 1);
    send_rx(8'h26, 4, 1);
    chk("R9 stamp equals timer", int'(m_rx_valid), 1);
    take_rx();
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_timer();
    t_read();
    t_tx_stamp();
    t_tx_late();
    t_rx_wait();
    t_rx_window();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule